// File: doc/BRIEF.md
# Duty-Cycled Memory Traffic Generator

This block produces an adjustable stream of line-sized memory requests, used to load a shared DRAM with a known amount of background traffic. Its request rate is set by the ratio of two numbers. A burst count says how many line requests go out back to back. An idle count says how many empty cycles follow each burst. A single idle count of zero gives traffic at full rate. A burst of one with a long idle gap gives the finest control of the rate.

Requests leave on a valid/ready port. Each request carries a line address inside a power-of-two region that starts at a programmed base. The line addresses walk the region either in ascending order or in a scrambled order taken from a maximal-length LFSR. Each request is a read, or the requests alternate between read and write. The generator either covers the region once and then stops with a done flag, or it keeps circling the region until a stop pulse arrives.

Counters report the number of lines accepted, the cycles elapsed since launch, the length of a single pass in cycles, and the number of completions seen on a response strobe. These let software compute the rate that was actually achieved.

Top module: `mem_traffic_gen`

## Requirements
- R1: After reset the block is idle: req_valid, busy and done are low, and all four statistics read zero.
- R2: Each burst holds exactly max(cfg_burst,1) accepted requests. The next burst follows after exactly cfg_gap cycles with req_valid low. With cfg_gap = 0 the bursts run back to back, so the accepts fall on consecutive cycles. cfg_gap may be as large as 4500 or more.
- R3: While req_valid is high and req_ready is low, req_valid, req_addr and req_we hold steady. The idle gap starts counting only after the last request of the burst has been accepted, so back-pressure never shortens a gap.
- R4: In sequential mode (cfg_random = 0) the n-th accepted request of a run has address cfg_base + (n mod 2^k) * LINE_BYTES. Here k is the region size in lines, given as log2.
- R5: In random mode (cfg_random = 1) one pass of 2^k requests starts at line slot 0 and visits every slot of the region exactly once, in a non-ascending order.
- R6: With cfg_mixed = 0 every request has req_we = 0 (read). With cfg_mixed = 1 the accepted requests alternate read, write, read, … starting with a read after each launch.
- R7: With cfg_single = 1, after 2^k accepted requests no further request is raised. done then rises and stays high until the next launch or a stop. With cfg_single = 0 the walk wraps and continues.
- R8: A stop pulse ends a run. If a request is pending it is completed first (accepted). The block then returns to idle, with busy low and no further requests.
- R9: A start pulse launches a run and captures all cfg_* inputs only when the block is not busy. Changes to the cfg_* inputs, and start pulses, while busy have no effect on the run.
- R10: stat_lines counts the requests accepted since launch. stat_cycles counts every cycle after launch until the block returns to idle. stat_pass_cycles records, on single-pass completion, the cycles from the first request cycle through the last accept cycle. With full-rate ready this equals N + (ceil(N/A) − 1) * C.
- R11: stat_rsp counts the cycles with rsp_valid high since the last launch.
- R12: cfg_size_log2 below 2 is treated as 2, and above 16 it is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; captures the configuration |
| stop | input | 1 | Ends a running or finished run |
| cfg_base | input | ADDR_W | Byte base of the region, line aligned |
| cfg_size_log2 | input | 5 | Region size as log2 of line count |
| cfg_burst | input | 16 | Requests per burst (0 acts as 1) |
| cfg_gap | input | 16 | Idle cycles after each burst |
| cfg_random | input | 1 | 1 = LFSR line order, 0 = ascending |
| cfg_mixed | input | 1 | 1 = alternate read/write, 0 = reads only |
| cfg_single | input | 1 | 1 = one pass then done, 0 = loop |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Line-aligned byte address |
| req_we | output | 1 | 1 = write, 0 = read |
| rsp_valid | input | 1 | One completion returned |
| busy | output | 1 | A burst or gap is in progress |
| done | output | 1 | Single pass finished |
| stat_lines | output | STAT_W | Accepted requests since launch |
| stat_cycles | output | STAT_W | Cycles since launch |
| stat_pass_cycles | output | STAT_W | Length of the completed single pass |
| stat_rsp | output | STAT_W | Completions since launch |

## Verification
The hardest case to reach from the ports is back-pressure that lands on the final request of a burst, or on a request just before a stop. In that case the gap counter and the stop must wait for an accept that is held off. The bench drives req_ready from a pseudo-random sequence during a mixed read/write run with short bursts. It counts every busy cycle with req_valid low. This total must equal the number of gaps times the gap length exactly, no matter how long each request stalls. Separately, a stop is issued into a looping run whose configuration inputs and start line are disturbed while busy. The bench then confirms that the accepted addresses never changed base and that no request follows the return to idle.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    localparam int unsigned SLOT_W = 16;
    localparam int unsigned K_W    = 5;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned K_MIN  = 2;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [K_W-1:0]    klog_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BURST = 2'd1,
        PH_GAP   = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        klog_t k;
        slot_t size_m1;
        cnt_t  burst_m1;
        cnt_t  gap;
        logic  random;
        logic  mixed;
        logic  single;
    } run_cfg_t;

    function automatic slot_t lfsr_taps(input klog_t k);
        case (k)
            5'd2:    return 16'h0003;
            5'd3:    return 16'h0006;
            5'd4:    return 16'h000C;
            5'd5:    return 16'h0014;
            5'd6:    return 16'h0030;
            5'd7:    return 16'h0060;
            5'd8:    return 16'h00B8;
            5'd9:    return 16'h0110;
            5'd10:   return 16'h0240;
            5'd11:   return 16'h0500;
            5'd12:   return 16'h0829;
            5'd13:   return 16'h100D;
            5'd14:   return 16'h2015;
            5'd15:   return 16'h6000;
            5'd16:   return 16'hD008;
            default: return 16'h0003;
        endcase
    endfunction

    function automatic slot_t lfsr_step(input slot_t s, input klog_t k);
        if (s[0]) return (s >> 1) ^ lfsr_taps(k);
        return s >> 1;
    endfunction

    function automatic klog_t clamp_k(input klog_t raw);
        if (raw < klog_t'(K_MIN)) return klog_t'(K_MIN);
        if (raw > klog_t'(SLOT_W)) return klog_t'(SLOT_W);
        return raw;
    endfunction

    function automatic slot_t size_mask(input klog_t k);
        return slot_t'((32'd1 << k) - 32'd1);
    endfunction

endpackage

// File: rtl/mtg_addr_gen.sv
module mtg_addr_gen
    import mtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  launch,
    input  logic  advance,
    input  logic  random,
    input  klog_t k,
    input  slot_t size_m1,
    output slot_t slot
);

    slot_t slot_q;
    slot_t stepped;
    slot_t slot_nxt;

    always_comb begin
        stepped = lfsr_step(slot_q, k);
        if (random) begin
            if (slot_q == '0)
                slot_nxt = slot_t'(1);
            else if (stepped == slot_t'(1))
                slot_nxt = '0;
            else
                slot_nxt = stepped;
        end else begin
            slot_nxt = (slot_q + slot_t'(1)) & size_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (launch)
            slot_q <= '0;
        else if (advance)
            slot_q <= slot_nxt;
    end

    assign slot = slot_q;

    AST_SLOT_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        !launch |=> ((slot_q & ~size_m1) == '0)); // R5

endmodule

// File: rtl/mtg_phase_ctrl.sv
module mtg_phase_ctrl
    import mtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   stop,
    input  logic   accept,
    input  slot_t  size_m1,
    input  cnt_t   burst_m1,
    input  cnt_t   gap,
    input  logic   single,
    output logic   launch,
    output logic   finish,
    output phase_e phase
);

    phase_e phase_q;
    cnt_t   burst_cnt;
    cnt_t   gap_cnt;
    slot_t  pass_idx;
    logic   stop_pend;
    logic   eff_stop;
    logic   burst_end;
    logic   pass_last;

    always_comb begin
        launch    = start && (phase_q == PH_IDLE || phase_q == PH_DONE);
        eff_stop  = stop || stop_pend;
        burst_end = burst_cnt == burst_m1;
        pass_last = pass_idx == size_m1;
        finish    = (phase_q == PH_BURST) && accept && single && pass_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            burst_cnt <= '0;
            gap_cnt   <= '0;
            pass_idx  <= '0;
            stop_pend <= 1'b0;
        end else if (launch) begin
            phase_q   <= PH_BURST;
            burst_cnt <= '0;
            gap_cnt   <= '0;
            pass_idx  <= '0;
            stop_pend <= 1'b0;
        end else begin
            case (phase_q)
                PH_BURST: begin
                    if (accept) begin
                        pass_idx <= pass_last ? '0 : pass_idx + slot_t'(1);
                        if (finish) begin
                            phase_q   <= PH_DONE;
                            stop_pend <= 1'b0;
                        end else if (eff_stop) begin
                            phase_q   <= PH_IDLE;
                            stop_pend <= 1'b0;
                        end else if (burst_end) begin
                            burst_cnt <= '0;
                            gap_cnt   <= '0;
                            if (gap != '0) phase_q <= PH_GAP;
                        end else begin
                            burst_cnt <= burst_cnt + cnt_t'(1);
                        end
                    end else if (stop) begin
                        stop_pend <= 1'b1;
                    end
                end
                PH_GAP: begin
                    if (eff_stop) begin
                        phase_q   <= PH_IDLE;
                        stop_pend <= 1'b0;
                    end else if (gap_cnt == gap - cnt_t'(1)) begin
                        phase_q <= PH_BURST;
                        gap_cnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + cnt_t'(1);
                    end
                end
                PH_DONE: begin
                    if (stop) phase_q <= PH_IDLE;
                end
                default: begin
                    stop_pend <= 1'b0;
                end
            endcase
        end
    end

    assign phase = phase_q;

    AST_GAP_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP) |-> (gap_cnt < gap)); // R2
    AST_BURST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BURST) |-> (burst_cnt <= burst_m1)); // R2
    AST_DONE_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !start && !stop) |=> (phase_q == PH_DONE)); // R7

endmodule

// File: rtl/mtg_stats.sv
module mtg_stats #(
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              accept,
    input  logic              active,
    input  logic              finish,
    input  logic              rsp_valid,
    output logic [STAT_W-1:0] lines,
    output logic [STAT_W-1:0] cycles,
    output logic [STAT_W-1:0] pass_cycles,
    output logic [STAT_W-1:0] rsp_cnt
);

    localparam logic [STAT_W-1:0] ONE = STAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            lines       <= '0;
            cycles      <= '0;
            pass_cycles <= '0;
            rsp_cnt     <= '0;
        end else begin
            if (accept)    lines   <= lines + ONE;
            if (active)    cycles  <= cycles + ONE;
            if (rsp_valid) rsp_cnt <= rsp_cnt + ONE;
            if (finish)    pass_cycles <= cycles + ONE;
        end
    end

    AST_LINES_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !launch |=> (lines == $past(lines) || lines == $past(lines) + ONE)); // R10
    AST_IDLE_NO_LINES: assert property (@(posedge clk) disable iff (rst)
        (!active && !launch) |=> (lines == $past(lines))); // R10

endmodule

// File: rtl/mem_traffic_gen.sv
module mem_traffic_gen
    import mtg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned STAT_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [K_W-1:0]    cfg_size_log2,
    input  logic [CNT_W-1:0]  cfg_burst,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic              cfg_random,
    input  logic              cfg_mixed,
    input  logic              cfg_single,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_we,
    input  logic              rsp_valid,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] stat_lines,
    output logic [STAT_W-1:0] stat_cycles,
    output logic [STAT_W-1:0] stat_pass_cycles,
    output logic [STAT_W-1:0] stat_rsp
);

    localparam int unsigned LINE_SH = $clog2(LINE_BYTES);

    run_cfg_t          cfg_q;
    run_cfg_t          cfg_d;
    logic [ADDR_W-1:0] base_q;
    logic              launch;
    logic              finish;
    logic              accept;
    logic              we_tgl;
    phase_e            phase;
    slot_t             slot;
    klog_t             k_eff;

    always_comb begin
        k_eff          = clamp_k(cfg_size_log2);
        cfg_d.k        = k_eff;
        cfg_d.size_m1  = size_mask(k_eff);
        cfg_d.burst_m1 = (cfg_burst == '0) ? '0 : cfg_burst - cnt_t'(1);
        cfg_d.gap      = cfg_gap;
        cfg_d.random   = cfg_random;
        cfg_d.mixed    = cfg_mixed;
        cfg_d.single   = cfg_single;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= '0;
            we_tgl <= 1'b0;
        end else if (launch) begin
            cfg_q  <= cfg_d;
            base_q <= cfg_base;
            we_tgl <= 1'b0;
        end else if (accept) begin
            we_tgl <= ~we_tgl;
        end
    end

    mtg_phase_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .accept   (accept),
        .size_m1  (cfg_q.size_m1),
        .burst_m1 (cfg_q.burst_m1),
        .gap      (cfg_q.gap),
        .single   (cfg_q.single),
        .launch   (launch),
        .finish   (finish),
        .phase    (phase)
    );

    mtg_addr_gen addr_i (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .advance (accept),
        .random  (cfg_q.random),
        .k       (cfg_q.k),
        .size_m1 (cfg_q.size_m1),
        .slot    (slot)
    );

    mtg_stats #(.STAT_W(STAT_W)) stats_i (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .accept      (accept),
        .active      (phase != PH_IDLE),
        .finish      (finish),
        .rsp_valid   (rsp_valid),
        .lines       (stat_lines),
        .cycles      (stat_cycles),
        .pass_cycles (stat_pass_cycles),
        .rsp_cnt     (stat_rsp)
    );

    always_comb begin
        req_valid = phase == PH_BURST;
        accept    = req_valid && req_ready;
        req_addr  = base_q + (ADDR_W'(slot) << LINE_SH);
        req_we    = cfg_q.mixed && we_tgl;
        busy      = (phase == PH_BURST) || (phase == PH_GAP);
        done      = phase == PH_DONE;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !stop) |=>
            (req_valid && $stable(req_addr) && $stable(req_we))); // R3
    AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (((req_addr - base_q) >> LINE_SH) <= ADDR_W'(cfg_q.size_m1))); // R4
    AST_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_q.mixed) |-> !req_we); // R6

endmodule

// File: tb/mem_traffic_gen_tb_top.sv
module mem_traffic_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size_log2 = '0;
    logic [15:0] cfg_burst = '0;
    logic [15:0] cfg_gap = '0;
    logic        cfg_random = 1'b0;
    logic        cfg_mixed = 1'b0;
    logic        cfg_single = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic        req_we;
    logic        rsp_valid = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] stat_lines;
    logic [31:0] stat_cycles;
    logic [31:0] stat_pass_cycles;
    logic [31:0] stat_rsp;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mem_traffic_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
        .cfg_burst(cfg_burst), .cfg_gap(cfg_gap),
        .cfg_random(cfg_random), .cfg_mixed(cfg_mixed), .cfg_single(cfg_single),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .rsp_valid(rsp_valid), .busy(busy), .done(done),
        .stat_lines(stat_lines), .stat_cycles(stat_cycles),
        .stat_pass_cycles(stat_pass_cycles), .stat_rsp(stat_rsp)
    );

    // ready driver: always 1, or pseudo-random
    logic       rdy_rand = 1'b0;
    logic [7:0] rdy_lfsr = 8'h5A;
    always @(posedge clk) begin
        #1;
        rdy_lfsr  <= {rdy_lfsr[6:0], rdy_lfsr[7] ^ rdy_lfsr[5] ^ rdy_lfsr[4] ^ rdy_lfsr[3]};
        req_ready <= rdy_rand ? rdy_lfsr[0] : 1'b1;
    end

    // monitor, sampled at the falling edge
    int          cyc = 0;
    int          n_acc = 0;
    logic [31:0] acc_addr [0:511];
    logic        acc_we   [0:511];
    int          acc_t    [0:511];
    int          hold_bad = 0;
    int          low_cnt  = 0;
    logic        hold_prev = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        prev_we = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (hold_prev && !(req_valid && req_addr == prev_addr && req_we == prev_we))
            hold_bad++;
        hold_prev = req_valid && !req_ready;
        prev_addr = req_addr;
        prev_we   = req_we;
        if (busy && !req_valid) low_cnt++;
        if (req_valid && req_ready && n_acc < 512) begin
            acc_addr[n_acc] = req_addr;
            acc_we[n_acc]   = req_we;
            acc_t[n_acc]    = cyc;
            n_acc++;
        end
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic launch(input logic [31:0] base, input logic [4:0] klog,
                          input int a, input int c, input bit rnd,
                          input bit mix, input bit sgl);
        @(posedge clk); #1;
        cfg_base = base; cfg_size_log2 = klog;
        cfg_burst = 16'(a); cfg_gap = 16'(c);
        cfg_random = rnd; cfg_mixed = mix; cfg_single = sgl;
        start = 1'b1;
        n_acc = 0; hold_bad = 0; low_cnt = 0;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!req_valid && !busy && !done, "R1", "control outputs idle",
            {req_valid, busy, done}, 0);
        chk(stat_lines == 0 && stat_cycles == 0 && stat_pass_cycles == 0 && stat_rsp == 0,
            "R1", "statistics zero", stat_lines + stat_cycles + stat_rsp, 0);
    endtask

    task automatic t_seq_burst_gap;
        int bad_addr = 0, bad_t = 0, bad_we = 0;
        launch(32'h0000_4000, 5'd4, 4, 3, 0, 0, 1);
        wait_done(2000);
        chk(done, "R7", "single pass done", done, 1);
        chk(n_acc == 16, "R7", "line count in single pass", n_acc, 16);
        for (int i = 0; i < 16; i++) begin
            if (acc_addr[i] != 32'h4000 + 32'(i * 64)) bad_addr++;
            if (acc_t[i] - acc_t[0] != (i / 4) * 7 + (i % 4)) bad_t++;
            if (acc_we[i]) bad_we++;
        end
        chk(bad_addr == 0, "R4", "ascending addresses", bad_addr, 0);
        chk(bad_t == 0, "R2", "burst/gap accept timing", bad_t, 0);
        chk(bad_we == 0, "R6", "read-only mode", bad_we, 0);
        chk(stat_lines == 16, "R10", "stat_lines", stat_lines, 16);
        chk(stat_pass_cycles == 25, "R10", "stat_pass_cycles", stat_pass_cycles, 25);
        tick(5);
        @(negedge clk);
        chk(stat_cycles == 30, "R10", "stat_cycles after done", stat_cycles, 30);
        chk(n_acc == 16 && !req_valid && done, "R7", "no request after done", n_acc, 16);
    endtask

    task automatic t_full_rate;
        int bad_t = 0;
        launch(32'h0, 5'd3, 0, 0, 0, 0, 1);
        wait_done(200);
        for (int i = 0; i < 8; i++)
            if (acc_t[i] - acc_t[0] != i) bad_t++;
        chk(n_acc == 8 && bad_t == 0, "R2", "zero gap back to back", bad_t, 0);
        chk(stat_pass_cycles == 8, "R10", "pass cycles at full rate", stat_pass_cycles, 8);
    endtask

    task automatic t_random(input logic [4:0] klog, input int a, input int c);
        int size = 1 << klog;
        int seen [0:31];
        int dup = 0, ordered = 0;
        for (int i = 0; i < 32; i++) seen[i] = 0;
        launch(32'h0010_0000, klog, a, c, 1, 0, 1);
        wait_done(2000);
        chk(n_acc == size, "R5", "random pass length", n_acc, size);
        chk(acc_addr[0] == 32'h0010_0000, "R5", "random pass starts at slot 0",
            acc_addr[0], 32'h0010_0000);
        for (int i = 0; i < size; i++) begin
            int s = int'((acc_addr[i] - 32'h0010_0000) >> 6);
            if (s < 0 || s >= size) dup++;
            else begin
                if (seen[s] != 0) dup++;
                seen[s]++;
            end
            if (s == i) ordered++;
        end
        chk(dup == 0, "R5", "each slot once", dup, 0);
        chk(ordered < size, "R5", "order not ascending", ordered, size - 1);
    endtask

    task automatic t_mixed_backpressure;
        int bad_we = 0;
        launch(32'h0000_8000, 5'd3, 2, 3, 0, 1, 1);
        rdy_rand = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1; rsp_valid = 1'b1;
            @(posedge clk); #1; rsp_valid = 1'b0;
        end
        wait_done(2000);
        rdy_rand = 1'b0;
        chk(n_acc == 8, "R7", "lines under back-pressure", n_acc, 8);
        for (int i = 0; i < 8; i++)
            if (acc_we[i] != 1'(i % 2)) bad_we++;
        chk(bad_we == 0, "R6", "read/write alternation", bad_we, 0);
        chk(hold_bad == 0, "R3", "request held while stalled", hold_bad, 0);
        chk(low_cnt == 9, "R3", "gap cycles independent of stalls", low_cnt, 9);
        chk(stat_rsp == 5, "R11", "completion count", stat_rsp, 5);
    endtask

    task automatic t_continuous_stop;
        int bad = 0, n_stop;
        launch(32'h0000_1000, 5'd2, 1, 1, 0, 0, 0);
        tick(3);
        cfg_base = 32'h0000_9000; cfg_size_log2 = 5'd5; cfg_gap = 16'd0;
        start = 1'b1; tick(1); start = 1'b0;
        for (int i = 0; i < 200 && n_acc < 12; i++) @(negedge clk);
        for (int i = 0; i < n_acc; i++)
            if (acc_addr[i] != 32'h1000 + 32'((i % 4) * 64)) bad++;
        chk(n_acc >= 12 && bad == 0, "R4", "wrap in looping run", bad, 0);
        chk(bad == 0, "R9", "busy-time config and start ignored", bad, 0);
        chk(busy && !done, "R7", "looping run still busy", busy, 1);
        @(posedge clk); #1; stop = 1'b1;
        @(posedge clk); #1; stop = 1'b0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        n_stop = n_acc;
        tick(10);
        @(negedge clk);
        chk(!busy && !req_valid && !done, "R8", "idle after stop", busy, 0);
        chk(n_acc == n_stop, "R8", "no request after stop", n_acc, n_stop);
    endtask

    task automatic t_clamp;
        launch(32'h0, 5'd0, 1, 0, 0, 0, 1);
        wait_done(200);
        chk(n_acc == 4, "R12", "size log2 below 2 clamped", n_acc, 4);
    endtask

    task automatic t_long_gap;
        launch(32'h0002_0000, 5'd2, 1, 4500, 0, 0, 1);
        wait_done(20000);
        chk(n_acc == 4 && acc_t[3] - acc_t[0] == 3 * 4501, "R2", "4500-cycle gap spacing",
            acc_t[3] - acc_t[0], 3 * 4501);
        chk(stat_pass_cycles == 13504, "R10", "pass cycles with long gap",
            stat_pass_cycles, 13504);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        t_reset();
        t_seq_burst_gap();
        t_full_rate();
        t_random(5'd4, 64, 0);
        t_random(5'd5, 1, 2);
        t_mixed_backpressure();
        t_continuous_stop();
        t_clamp();
        t_long_gap();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule